// File: doc/BRIEF.md
# Bridged Hot-Plug Register Access Sequencer

This block carries out one byte-wide register access to a hot-plug controller that can only be reached through a memory-mapped I2C master bridge. A host presents one request: the addressing mode, the direction, a 7-bit device address, a register index and, for a write, the data byte. The block then drives a simple 32-bit register bus through a fixed series of stores and loads. It programs the bridge's operation setup register and loads the message buffer. It sets the start flag through the bridge's OR-store alias. It then polls twice: first until the start flag drops, then until the error and busy bits of the status register are clear. At the end it returns the read byte or an error code.

The bridge keeps its words in the opposite byte order to the sequencer, so every word is byte-swapped at the bus edge. Each polling phase is bounded by a maximum number of attempts, and the attempts within a phase are spaced by a delay the host sets. The block accepts one request at a time. A request is taken only while the block is idle. The result comes with a done pulse that lasts one cycle.

Top module: `bridge_access_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o` and `bus_stb_o` are low.
- R2: With `req_mode_i` = 2'b01 (addressed), the setup word is 0x00010000 for a read or 0x40010000 for a write. The device address shifted right by one sits in bits 15:8 and the register index sits in bits 7:0.
- R3: With `req_mode_i` = 2'b10 (direct), the setup word is 0x10010000 for a read or 0x60010000 for a write, with the register index in bits 15:8 and zeros in bits 7:0.
- R4: The first three bus accesses are stores, in this order:
  - the setup word to offset 0x0010;
  - the message buffer at 0x0008, which receives the setup word for a read, or the data byte in bits 7:0 with all other bits zero for a write;
  - 0x00000002 to 0x2020, the OR alias of the control register.
  The plain control offset 0x0020 is never written.
- R5: The block then loads offset 0x0020 until bit 1 reads as 0. After 60 loads that all show bit 1 set, it ends with `err_o` = 2.
- R6: The block next loads offset 0x0070 until none of the bits in mask 0x00000A76 is set; bits outside the mask have no effect. After 60 failing loads it ends with `err_o` = 3.
- R7: For a read that passes both polls, the block makes one load of offset 0x0008 and returns bits 7:0 of that word on `rdata_o`. A write ends after the status poll with no such load. `rdata_o` is 0 for writes and errors.
- R8: Every word on `bus_wdata_o` and `bus_rdata_i` is the byte-swapped form of the value the block means (byte 0 and byte 3 exchanged, byte 1 and byte 2 exchanged).
- R9: A request with `req_mode_i` of 2'b00 or 2'b11 ends with `err_o` = 1 and makes no bus access.
- R10: Two successive loads of the same polled register start at least `poll_gap_i`+2 cycles apart.
- R11: Only one request is in flight at a time:
  - `req_i` is ignored while `busy_o` is high;
  - each accepted request produces exactly one `done_o` pulse, one cycle long, with `err_o` = 0 on success;
  - `bus_stb_o` holds its address until `bus_ack_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request strobe, taken only when idle |
| req_mode_i | input | 2 | 01 addressed, 10 direct, others unsupported |
| req_write_i | input | 1 | 1 for a write, 0 for a read |
| req_dev_i | input | 7 | Device address on the I2C segment |
| req_index_i | input | 8 | Register index within the controller |
| req_wbyte_i | input | 8 | Byte to write |
| poll_gap_i | input | GAP_W | Idle cycles inserted between polling attempts |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle pulse with the result |
| err_o | output | 2 | 0 ok, 1 bad mode, 2 start timeout, 3 status timeout |
| rdata_o | output | 8 | Byte returned by a read |
| bus_stb_o | output | 1 | Bus access strobe, held until acknowledged |
| bus_we_o | output | 1 | Bus store when high, load when low |
| bus_addr_o | output | ADDR_W | Bus byte offset |
| bus_wdata_o | output | 32 | Store data, byte-swapped |
| bus_rdata_i | input | 32 | Load data, byte-swapped |
| bus_ack_i | input | 1 | Bus access acknowledge |

## Verification
The bench aims at the attempt limits on both sides of the boundary. A controller that stays busy for 59 polls must still succeed; one that stays busy for 60 polls must time out. An off-by-one limit would pass the first case and fail the second, or the reverse. Status words with every bit outside the mask set must pass, so a design that tested the whole word would time out. A missing swap or a wrong shift of the device address would show up as a corrupted setup or buffer word. A start flag stored without the OR alias would leave the bridge idle, so the poll counts would come out wrong. Requests sent while the block is busy, and unsupported modes, must leave no extra done pulse and no bus traffic. A spacing check catches a design that ignores the poll gap.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef enum logic [1:0] {
        MODE_NONE   = 2'b00,
        MODE_ADDR   = 2'b01,
        MODE_DIRECT = 2'b10,
        MODE_RSVD   = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        ERR_NONE     = 2'd0,
        ERR_MODE     = 2'd1,
        ERR_CTL_TMO  = 2'd2,
        ERR_STAT_TMO = 2'd3
    } err_e;

    typedef enum logic [3:0] {
        S_IDLE, S_SETUP, S_LOAD, S_KICK,
        S_CTL_RD, S_CTL_GAP, S_STAT_RD, S_STAT_GAP,
        S_DATA_RD, S_DONE
    } state_e;

    typedef struct packed {
        mode_e      mode;
        logic       write;
        logic [6:0] dev;
        logic [7:0] index;
        logic [7:0] wbyte;
    } req_t;

    // bridge register map (byte offsets)
    localparam logic [15:0] OFS_SETUP    = 16'h0010;
    localparam logic [15:0] OFS_MBUF     = 16'h0008;
    localparam logic [15:0] OFS_CTL      = 16'h0020;
    localparam logic [15:0] OFS_STAT     = 16'h0070;
    localparam logic [15:0] OFS_OR_ALIAS = 16'h2000;

    localparam logic [31:0] START_BIT = 32'h0000_0002;
    localparam logic [31:0] STAT_MASK = 32'h0000_0A76;

    localparam logic [31:0] OP_ADDR_RD = 32'h0001_0000;
    localparam logic [31:0] OP_ADDR_WR = 32'h4001_0000;
    localparam logic [31:0] OP_DIR_RD  = 32'h1001_0000;
    localparam logic [31:0] OP_DIR_WR  = 32'h6001_0000;

    function automatic logic [31:0] swap32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic mode_ok(input mode_e m);
        return (m == MODE_ADDR) || (m == MODE_DIRECT);
    endfunction

endpackage

// File: rtl/bseq_setup_word.sv
module bseq_setup_word
    import bseq_pkg::*;
(
    input  req_t        req_i,
    output logic [31:0] word_o
);
    logic unused_dev_lsb;
    assign unused_dev_lsb = req_i.dev[0];

    always_comb begin
        if (req_i.mode == MODE_DIRECT) begin
            word_o = (req_i.write ? OP_DIR_WR : OP_DIR_RD)
                   | {16'h0000, req_i.index, 8'h00};
        end else begin
            word_o = (req_i.write ? OP_ADDR_WR : OP_ADDR_RD)
                   | {16'h0000, 2'b00, req_i.dev[6:1], req_i.index};
        end
    end
endmodule

// File: rtl/bseq_bus_port.sv
module bseq_bus_port
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       word_i,
    output logic              done_o,
    output logic [31:0]       word_o,
    output logic              bus_stb_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [31:0]       bus_wdata_o,
    input  logic [31:0]       bus_rdata_i,
    input  logic              bus_ack_i
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_stb_o   <= 1'b0;
            bus_we_o    <= 1'b0;
            bus_addr_o  <= '0;
            bus_wdata_o <= '0;
        end else if (go_i) begin
            bus_stb_o   <= 1'b1;
            bus_we_o    <= we_i;
            bus_addr_o  <= addr_i;
            bus_wdata_o <= swap32(word_i);
        end else if (bus_stb_o && bus_ack_i) begin
            bus_stb_o   <= 1'b0;
        end
    end

    assign done_o = bus_stb_o && bus_ack_i;
    assign word_o = swap32(bus_rdata_i);

    // R11
    strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_stb_o && !bus_ack_i) |=> (bus_stb_o && $stable(bus_addr_o) && $stable(bus_we_o)));
endmodule

// File: rtl/bseq_poll_timer.sv
module bseq_poll_timer #(
    parameter int MAX_POLLS = 60,
    parameter int GAP_W     = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             miss_i,
    input  logic [GAP_W-1:0] gap_len_i,
    output logic             last_o,
    output logic             gap_zero_o
);
    localparam int CNT_W = $clog2(MAX_POLLS + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            gap_q <= '0;
        end else begin
            if (clr_i)       cnt_q <= '0;
            else if (miss_i) cnt_q <= cnt_q + CNT_W'(1);
            if (miss_i)           gap_q <= gap_len_i;
            else if (gap_q != '0) gap_q <= gap_q - GAP_W'(1);
        end
    end

    assign last_o     = (cnt_q == CNT_W'(MAX_POLLS - 1));
    assign gap_zero_o = (gap_q == '0);

    // R5
    attempt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CNT_W'(MAX_POLLS));
endmodule

// File: rtl/bridge_access_seq.sv
module bridge_access_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int GAP_W     = 16,
    parameter int MAX_POLLS = 60
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [1:0]        req_mode_i,
    input  logic              req_write_i,
    input  logic [6:0]        req_dev_i,
    input  logic [7:0]        req_index_i,
    input  logic [7:0]        req_wbyte_i,
    input  logic [GAP_W-1:0]  poll_gap_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [1:0]        err_o,
    output logic [7:0]        rdata_o,
    output logic              bus_stb_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [31:0]       bus_wdata_o,
    input  logic [31:0]       bus_rdata_i,
    input  logic              bus_ack_i
);
    localparam logic [ADDR_W-1:0] A_SETUP = ADDR_W'(OFS_SETUP);
    localparam logic [ADDR_W-1:0] A_MBUF  = ADDR_W'(OFS_MBUF);
    localparam logic [ADDR_W-1:0] A_CTL   = ADDR_W'(OFS_CTL);
    localparam logic [ADDR_W-1:0] A_KICK  = ADDR_W'(OFS_CTL | OFS_OR_ALIAS);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);

    state_e      state_q, state_d;
    req_t        req_q, req_in;
    err_e        err_q, err_d;
    logic [7:0]  rdata_q;
    logic        issued_q;
    logic [31:0] setup_w, rd_w, acc_word;
    logic [ADDR_W-1:0] acc_addr;
    logic        is_acc, acc_we, go, xfer_done;
    logic        t_clr, t_miss, t_last, gap_zero, set_err, cap_rd, accept;

    assign req_in = '{mode: mode_e'(req_mode_i), write: req_write_i, dev: req_dev_i,
                      index: req_index_i, wbyte: req_wbyte_i};
    assign accept = (state_q == S_IDLE) && req_i;

    bseq_setup_word u_setup (.req_i(req_q), .word_o(setup_w));

    bseq_bus_port #(.ADDR_W(ADDR_W)) u_port (
        .clk(clk), .rst(rst), .go_i(go), .we_i(acc_we), .addr_i(acc_addr),
        .word_i(acc_word), .done_o(xfer_done), .word_o(rd_w),
        .bus_stb_o(bus_stb_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
        .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i), .bus_ack_i(bus_ack_i)
    );

    bseq_poll_timer #(.MAX_POLLS(MAX_POLLS), .GAP_W(GAP_W)) u_timer (
        .clk(clk), .rst(rst), .clr_i(t_clr), .miss_i(t_miss),
        .gap_len_i(poll_gap_i), .last_o(t_last), .gap_zero_o(gap_zero)
    );

    always_comb begin
        state_d  = state_q;
        is_acc   = 1'b0;
        acc_we   = 1'b0;
        acc_addr = '0;
        acc_word = '0;
        t_clr    = 1'b0;
        t_miss   = 1'b0;
        set_err  = 1'b0;
        err_d    = ERR_NONE;
        cap_rd   = 1'b0;
        unique case (state_q)
            S_IDLE: if (req_i) state_d = mode_ok(req_in.mode) ? S_SETUP : S_DONE;
            S_SETUP: begin
                is_acc = 1'b1; acc_we = 1'b1; acc_addr = A_SETUP; acc_word = setup_w;
                if (xfer_done) state_d = S_LOAD;
            end
            S_LOAD: begin
                is_acc = 1'b1; acc_we = 1'b1; acc_addr = A_MBUF;
                acc_word = req_q.write ? {24'h0, req_q.wbyte} : setup_w;
                if (xfer_done) state_d = S_KICK;
            end
            S_KICK: begin
                is_acc = 1'b1; acc_we = 1'b1; acc_addr = A_KICK; acc_word = START_BIT;
                if (xfer_done) begin
                    state_d = S_CTL_RD;
                    t_clr   = 1'b1;
                end
            end
            S_CTL_RD: begin
                is_acc = 1'b1; acc_addr = A_CTL;
                if (xfer_done) begin
                    if ((rd_w & START_BIT) == '0) begin
                        state_d = S_STAT_RD;
                        t_clr   = 1'b1;
                    end else if (t_last) begin
                        state_d = S_DONE; set_err = 1'b1; err_d = ERR_CTL_TMO;
                    end else begin
                        state_d = S_CTL_GAP; t_miss = 1'b1;
                    end
                end
            end
            S_CTL_GAP: if (gap_zero) state_d = S_CTL_RD;
            S_STAT_RD: begin
                is_acc = 1'b1; acc_addr = A_STAT;
                if (xfer_done) begin
                    if ((rd_w & STAT_MASK) == '0) begin
                        state_d = req_q.write ? S_DONE : S_DATA_RD;
                    end else if (t_last) begin
                        state_d = S_DONE; set_err = 1'b1; err_d = ERR_STAT_TMO;
                    end else begin
                        state_d = S_STAT_GAP; t_miss = 1'b1;
                    end
                end
            end
            S_STAT_GAP: if (gap_zero) state_d = S_STAT_RD;
            S_DATA_RD: begin
                is_acc = 1'b1; acc_addr = A_MBUF;
                if (xfer_done) begin
                    state_d = S_DONE;
                    cap_rd  = 1'b1;
                end
            end
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    assign go = is_acc && !issued_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            issued_q <= 1'b0;
            req_q    <= '0;
            err_q    <= ERR_NONE;
            rdata_q  <= '0;
        end else begin
            state_q <= state_d;
            if (xfer_done) issued_q <= 1'b0;
            else if (go)   issued_q <= 1'b1;
            if (accept) begin
                req_q   <= req_in;
                err_q   <= mode_ok(req_in.mode) ? ERR_NONE : ERR_MODE;
                rdata_q <= '0;
            end
            if (set_err) err_q   <= err_d;
            if (cap_rd)  rdata_q <= rd_w[7:0];
        end
    end

    assign busy_o  = (state_q != S_IDLE);
    assign done_o  = (state_q == S_DONE);
    assign err_o   = err_q;
    assign rdata_o = rdata_q;

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !bus_stb_o);
    // R9
    bad_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !mode_ok(req_in.mode)) |=> (done_o && err_o == ERR_MODE && !bus_stb_o));
    // R4
    no_plain_ctl_store_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_stb_o && bus_we_o && bus_addr_o == A_CTL));
    // R7
    write_no_data_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_DATA_RD) |-> !req_q.write);
endmodule

// File: tb/bridge_access_seq_bench.sv
module bridge_access_seq_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic        req_i = 1'b0;
    logic [1:0]  req_mode_i = 2'b00;
    logic        req_write_i = 1'b0;
    logic [6:0]  req_dev_i = '0;
    logic [7:0]  req_index_i = '0;
    logic [7:0]  req_wbyte_i = '0;
    logic [15:0] poll_gap_i = '0;
    logic        busy_o, done_o, bus_stb_o, bus_we_o;
    logic [1:0]  err_o;
    logic [7:0]  rdata_o;
    logic [15:0] bus_addr_o;
    logic [31:0] bus_wdata_o;
    logic [31:0] bus_rdata_i = '0;
    logic        bus_ack_i = 1'b0;

    bridge_access_seq u_bridge_access_seq (
        .clk(clk), .rst(rst), .req_i(req_i), .req_mode_i(req_mode_i),
        .req_write_i(req_write_i), .req_dev_i(req_dev_i), .req_index_i(req_index_i),
        .req_wbyte_i(req_wbyte_i), .poll_gap_i(poll_gap_i), .busy_o(busy_o),
        .done_o(done_o), .err_o(err_o), .rdata_o(rdata_o), .bus_stb_o(bus_stb_o),
        .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
        .bus_rdata_i(bus_rdata_i), .bus_ack_i(bus_ack_i)
    );

    typedef struct {
        logic [1:0]  err;
        logic [7:0]  rdata;
        logic [31:0] setup;
        logic [31:0] mbuf;
        int          ctl_reads;
        int          stat_reads;
        int          data_reads;
        int          writes;
        int          gap;
    } exp_t;

    exp_t q[$];
    int n_chk = 0, n_err = 0, n_done = 0, n_issued = 0;

    // bridge model state
    int          cyc = 0;
    int          cfg_busy = 0, cfg_bad = 0;
    logic [7:0]  cfg_byte = '0;
    logic [31:0] m_setup, m_mbuf, m_ctl;
    int          rem_busy, rem_bad;
    int          c_ctl, c_stat, c_data, c_wr, c_plain, last_ctl, min_sp;
    logic [15:0] wr_addr [3];

    function automatic logic [31:0] sw(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            bus_ack_i <= 1'b0;
        end else if (bus_ack_i) begin
            bus_ack_i <= 1'b0;
        end else if (bus_stb_o) begin
            bus_ack_i   <= 1'b1;
            bus_rdata_i <= '0;
            if (bus_we_o) begin
                if (c_wr < 3) wr_addr[c_wr] = bus_addr_o;
                c_wr++;
                case (bus_addr_o)
                    16'h0010: m_setup = sw(bus_wdata_o);
                    16'h0008: m_mbuf  = sw(bus_wdata_o);
                    16'h2020: begin m_ctl = m_ctl | sw(bus_wdata_o); rem_busy = cfg_busy; end
                    16'h0020: c_plain++;
                    default: ;
                endcase
            end else begin
                case (bus_addr_o)
                    16'h0020: begin
                        if (c_ctl > 0 && (cyc - last_ctl) < min_sp) min_sp = cyc - last_ctl;
                        last_ctl = cyc;
                        c_ctl++;
                        if (rem_busy > 0) rem_busy--;
                        else m_ctl = m_ctl & ~32'h2;
                        bus_rdata_i <= sw(m_ctl);
                    end
                    16'h0070: begin
                        c_stat++;
                        if (rem_bad > 0) begin
                            rem_bad--;
                            bus_rdata_i <= sw((c_stat % 2) ? 32'h0000_0A76 : 32'h0000_0200);
                        end else begin
                            bus_rdata_i <= sw(32'hFFFF_F589);
                        end
                    end
                    16'h0008: begin
                        c_data++;
                        bus_rdata_i <= sw({24'h96C35A, cfg_byte});
                    end
                    default: ;
                endcase
            end
        end
    end

    // monitor: pop expected item on each done pulse
    always @(negedge clk) begin
        if (!rst && done_o) begin
            n_done++;
            if (q.size() == 0) begin
                chk(1'b0, "R11", "unexpected done pulse", 32'(err_o), 32'hFFFF_FFFF);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(err_o == e.err, "R5/R6/R9 r11_", "err_o", 32'(err_o), 32'(e.err));
                chk(rdata_o == e.rdata, "R7", "rdata_o", 32'(rdata_o), 32'(e.rdata));
                chk(c_ctl == e.ctl_reads, "R5", "control polls", 32'(c_ctl), 32'(e.ctl_reads));
                chk(c_stat == e.stat_reads, "R6", "status polls", 32'(c_stat), 32'(e.stat_reads));
                chk(c_data == e.data_reads, "R7", "buffer loads", 32'(c_data), 32'(e.data_reads));
                chk(c_wr == e.writes, "R4 R9", "store count", 32'(c_wr), 32'(e.writes));
                chk(c_plain == 0, "R4", "plain control stores", 32'(c_plain), 32'h0);
                if (e.writes == 3) begin
                    chk(m_setup == e.setup, "R2 R3 R8", "setup word", m_setup, e.setup);
                    chk(m_mbuf == e.mbuf, "R4 R8", "buffer word", m_mbuf, e.mbuf);
                    chk(wr_addr[0] == 16'h0010 && wr_addr[1] == 16'h0008 && wr_addr[2] == 16'h2020,
                        "R4", "store order", {wr_addr[0], wr_addr[1]}, {16'h0010, 16'h0008});
                end
                if (e.ctl_reads >= 2)
                    chk(min_sp >= e.gap + 2, "R10", "poll spacing", 32'(min_sp), 32'(e.gap + 2));
            end
        end
    end

    task automatic run_txn(input logic [1:0] mode, input logic we, input logic [6:0] dev,
                           input logic [7:0] idx, input logic [7:0] wb, input int busy_n,
                           input int bad_n, input logic [7:0] rb, input int gap, input bit poke);
        exp_t e;
        e.err = 2'd0; e.rdata = 8'h00; e.setup = '0; e.mbuf = '0;
        e.ctl_reads = 0; e.stat_reads = 0; e.data_reads = 0; e.writes = 0; e.gap = gap;
        if (mode == 2'b01 || mode == 2'b10) begin
            if (mode == 2'b01)
                e.setup = (we ? 32'h4001_0000 : 32'h0001_0000) | {16'h0, 1'b0, dev[6:1], idx};
            else
                e.setup = (we ? 32'h6001_0000 : 32'h1001_0000) | {16'h0, idx, 8'h00};
            e.mbuf   = we ? {24'h0, wb} : e.setup;
            e.writes = 3;
            if (busy_n >= 60) begin
                e.ctl_reads = 60; e.err = 2'd2;
            end else begin
                e.ctl_reads = busy_n + 1;
                if (bad_n >= 60) begin
                    e.stat_reads = 60; e.err = 2'd3;
                end else begin
                    e.stat_reads = bad_n + 1;
                    e.data_reads = we ? 0 : 1;
                    e.rdata      = we ? 8'h00 : rb;
                end
            end
        end else begin
            e.err = 2'd1;
        end
        @(negedge clk);
        cfg_busy = busy_n; cfg_bad = bad_n; cfg_byte = rb;
        rem_bad = bad_n; rem_busy = 0; m_ctl = '0; m_setup = '0; m_mbuf = '0;
        c_ctl = 0; c_stat = 0; c_data = 0; c_wr = 0; c_plain = 0; last_ctl = 0; min_sp = 1 << 30;
        q.push_back(e);
        n_issued++;
        req_mode_i = mode; req_write_i = we; req_dev_i = dev; req_index_i = idx;
        req_wbyte_i = wb; poll_gap_i = 16'(gap); req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        if (poke) begin
            // R11: requests while busy must be ignored
            repeat (4) @(negedge clk);
            req_mode_i = 2'b10; req_write_i = ~we; req_index_i = ~idx; req_i = 1'b1;
            @(negedge clk);
            req_mode_i = 2'b00; req_i = 1'b1;
            @(negedge clk);
            req_i = 1'b0;
        end
        while (n_done < n_issued) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(!busy_o, "R1", "busy after reset", 32'(busy_o), 32'h0);
        chk(!done_o, "R1", "done after reset", 32'(done_o), 32'h0);
        chk(!bus_stb_o, "R1", "strobe after reset", 32'(bus_stb_o), 32'h0);

        run_txn(2'b01, 1'b0, 7'h55, 8'h0F, 8'h00, 3, 2, 8'h3C, 0, 1'b0);   // R2 read
        run_txn(2'b01, 1'b1, 7'h20, 8'h04, 8'hA5, 0, 0, 8'h00, 4, 1'b0);   // R2 write
        run_txn(2'b10, 1'b0, 7'h11, 8'h1F, 8'h00, 5, 1, 8'hE1, 10, 1'b0);  // R3 read, R10
        run_txn(2'b10, 1'b1, 7'h7F, 8'h11, 8'h7E, 2, 3, 8'h00, 1, 1'b1);   // R3 write, R11
        run_txn(2'b00, 1'b0, 7'h01, 8'h01, 8'h00, 0, 0, 8'h00, 0, 1'b0);   // R9
        run_txn(2'b11, 1'b1, 7'h01, 8'h01, 8'h99, 0, 0, 8'h00, 0, 1'b0);   // R9
        run_txn(2'b01, 1'b0, 7'h0B, 8'h22, 8'h00, 59, 0, 8'h81, 1, 1'b0);  // R5 boundary ok
        run_txn(2'b01, 1'b0, 7'h0B, 8'h22, 8'h00, 60, 0, 8'h81, 0, 1'b0);  // R5 timeout
        run_txn(2'b10, 1'b1, 7'h00, 8'h33, 8'h0F, 0, 59, 8'h00, 0, 1'b0);  // R6 boundary ok
        run_txn(2'b10, 1'b0, 7'h00, 8'h33, 8'h00, 1, 60, 8'h44, 2, 1'b0);  // R6 timeout
        run_txn(2'b01, 1'b0, 7'h6A, 8'hC8, 8'h00, 1, 0, 8'hFF, 3, 1'b1);   // R7 R11

        chk(n_done == n_issued, "R11", "done pulse count", 32'(n_done), 32'(n_issued));
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule